// File: doc/BRIEF.md
# Address-Masked Hardware Breakpoint Unit

This block watches two address streams of a processor core: the address of the operation about to execute, and the address of the load or store about to reach memory. Each stream has its own group of breakpoint entries. Each entry holds a compare address, a compare mask and a control word. An entry matches when every address bit selected by a 1 in its mask equals the stored address bit. A mask with low-order zeros therefore covers an aligned range, and a mask with scattered zeros covers a strided set of addresses.

A match in the instruction group raises the instruction-breakpoint exception pulse. A match in the data group raises the data-breakpoint exception pulse. Each pulse comes with the number of the entry that caused it. Data entries can be set to fire on reads, on writes or on both. A single write port loads the address, mask and control values of any entry. Exception dispatch and the pipeline that consumes the pulses belong to the surrounding core.

Top module: `addr_watch_unit`

## Requirements
- R1: After synchronous reset, `ibrk_hit` and `dbrk_hit` are 0, both index outputs are 0, and every entry is disabled, so no access produces a hit until an entry is programmed.
- R2: An instruction entry matches a fetch when `((fetch_addr ^ addr) & mask) == 0`, where a mask bit of 1 means the bit is compared.
- R3: A data entry matches an access when `((dacc_addr ^ addr) & mask) == 0` and the access kind is allowed by the entry's control word.
- R4: An entry whose control bit 0 (enable) is 0 never matches, whatever its address and mask hold.
- R5: When several entries of one group match in the same cycle, the reported index is the lowest-numbered matching entry.
- R6: Data control bit 1 allows reads (`dacc_rd`) and bit 2 allows writes (`dacc_wr`). An access with both flags set matches if either allowed kind is present. Instruction entries ignore bits 1 and 2.
- R7: A fetch with `fetch_vld` low never hits. A data access with `dacc_vld` low, or with neither `dacc_rd` nor `dacc_wr` set, never hits.
- R8: Each hit output is registered. It is high for exactly the cycle after a qualifying address is presented and low after a cycle with no match.
- R9: While a hit output is low, its index output is 0.
- R10: A write with `cfg_we` high selects the group by `cfg_sel` (0 instruction, 1 data), the entry by `cfg_idx`, and the field by `cfg_field` (0 address, 1 mask, 2 control). The write is used from the next cycle on. Field code 3 is ignored, and a write never changes the other group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Group select: 0 instruction, 1 data |
| cfg_idx | input | CIW (2) | Entry number within the group |
| cfg_field | input | 2 | Field: 0 address, 1 mask, 2 control, 3 ignored |
| cfg_wdata | input | ADDR_W (32) | Write data |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_addr | input | ADDR_W (32) | Address of the operation about to execute |
| dacc_vld | input | 1 | Data access valid |
| dacc_rd | input | 1 | Access is a read |
| dacc_wr | input | 1 | Access is a write |
| dacc_addr | input | ADDR_W (32) | Address of the access about to happen |
| ibrk_hit | output | 1 | Instruction-breakpoint exception pulse |
| ibrk_idx | output | IIW (2) | Matching instruction entry |
| dbrk_hit | output | 1 | Data-breakpoint exception pulse |
| dbrk_idx | output | DIW (2) | Matching data entry |

## Verification
The hardest case to reach from the ports is several entries of one group with overlapping masked ranges that match in the same cycle while their read and write qualifiers differ. In that case the lowest matching entry must lose to a higher one whenever its access kind is not allowed. Random addresses almost never land in two ranges at once. The stimulus therefore builds each random address from a stored entry address with a few low bits flipped, and it draws masks as aligned ranges of random size so that ranges nest. Directed vectors pin down nested ranges, a read-and-write access, and an all-zero mask that matches every address.

// File: rtl/awu_pkg.sv
package awu_pkg;

   localparam int CTRL_W  = 3;
   localparam int CTRL_EN = 0;
   localparam int CTRL_RD = 1;
   localparam int CTRL_WR = 2;

   typedef enum logic [1:0] {
      FLD_ADDR = 2'd0,
      FLD_MASK = 2'd1,
      FLD_CTRL = 2'd2,
      FLD_NONE = 2'd3
   } awu_field_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/awu_entry_regs.sv
module awu_entry_regs
   import awu_pkg::*;
#(
   parameter int N      = 4,
   parameter int ADDR_W = 32,
   parameter int CIW    = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [CIW-1:0]               wr_idx,
   input  logic [1:0]                   wr_field,
   input  logic [ADDR_W-1:0]            wr_data,
   output logic [N-1:0][ADDR_W-1:0]     ent_addr,
   output logic [N-1:0][ADDR_W-1:0]     ent_mask,
   output logic [N-1:0][CTRL_W-1:0]     ent_ctrl
);

   if (CIW < idx_w(N)) begin : g_bad_ciw
      $error("awu_entry_regs: CIW too narrow for N");
   end

   for (genvar e = 0; e < N; e++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == CIW'(e));

      always_ff @(posedge clk) begin
         if (rst) begin
            ent_addr[e] <= '0;
            ent_mask[e] <= '0;
            ent_ctrl[e] <= '0;
         end else if (sel) begin
            unique case (awu_field_e'(wr_field))
               FLD_ADDR: ent_addr[e] <= wr_data;
               FLD_MASK: ent_mask[e] <= wr_data;
               FLD_CTRL: ent_ctrl[e] <= wr_data[CTRL_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   logic unused_hi;
   assign unused_hi = ^wr_data[ADDR_W-1:CTRL_W];

endmodule

// File: rtl/awu_match_bank.sv
module awu_match_bank
   import awu_pkg::*;
#(
   parameter int N       = 4,
   parameter int ADDR_W  = 32,
   parameter bit QUAL_RW = 1'b0
) (
   input  logic                     vld,
   input  logic                     rd,
   input  logic                     wr,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [N-1:0][ADDR_W-1:0] ent_addr,
   input  logic [N-1:0][ADDR_W-1:0] ent_mask,
   input  logic [N-1:0][CTRL_W-1:0] ent_ctrl,
   output logic [N-1:0]             hit_vec
);

   for (genvar e = 0; e < N; e++) begin : g_cmp
      logic addr_ok;
      logic kind_ok;

      assign addr_ok = ((addr ^ ent_addr[e]) & ent_mask[e]) == '0;

      if (QUAL_RW) begin : g_rw
         assign kind_ok = (rd && ent_ctrl[e][CTRL_RD]) ||
                          (wr && ent_ctrl[e][CTRL_WR]);
      end else begin : g_any
         logic unused_kind;
         assign unused_kind = ent_ctrl[e][CTRL_RD] ^ ent_ctrl[e][CTRL_WR];
         assign kind_ok = 1'b1;
      end

      assign hit_vec[e] = vld && ent_ctrl[e][CTRL_EN] && addr_ok && kind_ok;
   end

   if (!QUAL_RW) begin : g_no_rw
      logic unused_flags;
      assign unused_flags = rd ^ wr;
   end

endmodule

// File: rtl/awu_prio_pick.sv
module awu_prio_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   if ((1 << IW) < N) begin : g_bad_iw
      $error("awu_prio_pick: IW too narrow for N");
   end

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
   import awu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int N_INSN = 4,
   parameter int N_DATA = 4,
   localparam int IIW   = idx_w(N_INSN),
   localparam int DIW   = idx_w(N_DATA),
   localparam int CIW   = max2(IIW, DIW)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CIW-1:0]    cfg_idx,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              fetch_vld,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              dacc_vld,
   input  logic              dacc_rd,
   input  logic              dacc_wr,
   input  logic [ADDR_W-1:0] dacc_addr,
   output logic              ibrk_hit,
   output logic [IIW-1:0]    ibrk_idx,
   output logic              dbrk_hit,
   output logic [DIW-1:0]    dbrk_idx
);

   if (ADDR_W < CTRL_W) begin : g_bad_aw
      $error("addr_watch_unit: ADDR_W must hold the control word");
   end
   if (N_INSN < 1 || N_DATA < 1) begin : g_bad_n
      $error("addr_watch_unit: each group needs at least one entry");
   end

   logic [N_INSN-1:0][ADDR_W-1:0] i_addr, i_mask;
   logic [N_INSN-1:0][CTRL_W-1:0] i_ctrl;
   logic [N_DATA-1:0][ADDR_W-1:0] d_addr, d_mask;
   logic [N_DATA-1:0][CTRL_W-1:0] d_ctrl;
   logic [N_INSN-1:0]             i_hits, ien;
   logic [N_DATA-1:0]             d_hits, den;
   logic                          i_any, d_any;
   logic [IIW-1:0]                i_pick;
   logic [DIW-1:0]                d_pick;

   awu_entry_regs #(.N(N_INSN), .ADDR_W(ADDR_W), .CIW(CIW)) u_iregs (
      .clk(clk), .rst(rst),
      .wr_en(cfg_we && !cfg_sel), .wr_idx(cfg_idx),
      .wr_field(cfg_field), .wr_data(cfg_wdata),
      .ent_addr(i_addr), .ent_mask(i_mask), .ent_ctrl(i_ctrl)
   );

   awu_entry_regs #(.N(N_DATA), .ADDR_W(ADDR_W), .CIW(CIW)) u_dregs (
      .clk(clk), .rst(rst),
      .wr_en(cfg_we && cfg_sel), .wr_idx(cfg_idx),
      .wr_field(cfg_field), .wr_data(cfg_wdata),
      .ent_addr(d_addr), .ent_mask(d_mask), .ent_ctrl(d_ctrl)
   );

   awu_match_bank #(.N(N_INSN), .ADDR_W(ADDR_W), .QUAL_RW(1'b0)) u_ibank (
      .vld(fetch_vld), .rd(1'b0), .wr(1'b0), .addr(fetch_addr),
      .ent_addr(i_addr), .ent_mask(i_mask), .ent_ctrl(i_ctrl),
      .hit_vec(i_hits)
   );

   awu_match_bank #(.N(N_DATA), .ADDR_W(ADDR_W), .QUAL_RW(1'b1)) u_dbank (
      .vld(dacc_vld), .rd(dacc_rd), .wr(dacc_wr), .addr(dacc_addr),
      .ent_addr(d_addr), .ent_mask(d_mask), .ent_ctrl(d_ctrl),
      .hit_vec(d_hits)
   );

   awu_prio_pick #(.N(N_INSN), .IW(IIW)) u_ipick (
      .req(i_hits), .any(i_any), .idx(i_pick)
   );

   awu_prio_pick #(.N(N_DATA), .IW(DIW)) u_dpick (
      .req(d_hits), .any(d_any), .idx(d_pick)
   );

   for (genvar e = 0; e < N_INSN; e++) begin : g_ien
      assign ien[e] = i_ctrl[e][CTRL_EN];
   end
   for (genvar e = 0; e < N_DATA; e++) begin : g_den
      assign den[e] = d_ctrl[e][CTRL_EN];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ibrk_hit <= 1'b0;
         ibrk_idx <= '0;
         dbrk_hit <= 1'b0;
         dbrk_idx <= '0;
      end else begin
         ibrk_hit <= i_any;
         ibrk_idx <= i_any ? i_pick : '0;
         dbrk_hit <= d_any;
         dbrk_idx <= d_any ? d_pick : '0;
      end
   end

endmodule

// File: rtl/awu_checker.sv
module awu_checker #(
   parameter int N_INSN = 4,
   parameter int N_DATA = 4,
   parameter int IIW    = 2,
   parameter int DIW    = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              fetch_vld,
   input logic              dacc_vld,
   input logic              dacc_rd,
   input logic              dacc_wr,
   input logic              ibrk_hit,
   input logic [IIW-1:0]    ibrk_idx,
   input logic              dbrk_hit,
   input logic [DIW-1:0]    dbrk_idx,
   input logic [N_INSN-1:0] ien,
   input logic [N_DATA-1:0] den
);

   logic [N_INSN-1:0] ien_d;
   logic [N_DATA-1:0] den_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         ien_d <= '0;
         den_d <= '0;
      end else begin
         ien_d <= ien;
         den_d <= den;
      end
   end

   p_fetch_qual_r7: assert property (@(posedge clk) disable iff (rst)
      ibrk_hit |-> $past(fetch_vld));

   p_data_qual_r7: assert property (@(posedge clk) disable iff (rst)
      dbrk_hit |-> $past(dacc_vld && (dacc_rd || dacc_wr)));

   p_ien_r4: assert property (@(posedge clk) disable iff (rst)
      ibrk_hit |-> ien_d[ibrk_idx]);

   p_den_r4: assert property (@(posedge clk) disable iff (rst)
      dbrk_hit |-> den_d[dbrk_idx]);

   p_iidx_zero_r9: assert property (@(posedge clk) disable iff (rst)
      !ibrk_hit |-> ibrk_idx == '0);

   p_didx_zero_r9: assert property (@(posedge clk) disable iff (rst)
      !dbrk_hit |-> dbrk_idx == '0);

   p_reset_r1: assert property (@(posedge clk)
      $past(rst) |-> !ibrk_hit && !dbrk_hit);

endmodule

bind addr_watch_unit awu_checker #(
   .N_INSN(N_INSN), .N_DATA(N_DATA), .IIW(IIW), .DIW(DIW)
) u_chk (
   .clk(clk), .rst(rst),
   .fetch_vld(fetch_vld), .dacc_vld(dacc_vld),
   .dacc_rd(dacc_rd), .dacc_wr(dacc_wr),
   .ibrk_hit(ibrk_hit), .ibrk_idx(ibrk_idx),
   .dbrk_hit(dbrk_hit), .dbrk_idx(dbrk_idx),
   .ien(ien), .den(den)
);

// File: tb/sim_addr_watch_unit.sv
`timescale 1ns/1ps
module sim_addr_watch_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [1:0]  cfg_idx = '0, cfg_field = '0;
   logic [31:0] cfg_wdata = '0;
   logic        fetch_vld = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        dacc_vld = 1'b0, dacc_rd = 1'b0, dacc_wr = 1'b0;
   logic [31:0] dacc_addr = '0;
   logic        ibrk_hit, dbrk_hit;
   logic [1:0]  ibrk_idx, dbrk_idx;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [31:0] m_ia [4], m_im [4], m_da [4], m_dm [4];
   logic [2:0]  m_ic [4], m_dc [4];

   always #2.5 clk = ~clk;

   addr_watch_unit u0 (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .dacc_vld(dacc_vld), .dacc_rd(dacc_rd), .dacc_wr(dacc_wr),
      .dacc_addr(dacc_addr),
      .ibrk_hit(ibrk_hit), .ibrk_idx(ibrk_idx),
      .dbrk_hit(dbrk_hit), .dbrk_idx(dbrk_idx)
   );

   function automatic logic [2:0] exp_ins(input logic v, input logic [31:0] a);
      for (int e = 0; e < 4; e++)
         if (v && m_ic[e][0] && (((a ^ m_ia[e]) & m_im[e]) == 0))
            return {1'b1, 2'(e)};
      return 3'b000;
   endfunction

   function automatic logic [2:0] exp_dat(input logic v, input logic r,
                                          input logic w, input logic [31:0] a);
      for (int e = 0; e < 4; e++)
         if (v && m_dc[e][0] && ((r && m_dc[e][1]) || (w && m_dc[e][2])) &&
             (((a ^ m_da[e]) & m_dm[e]) == 0))
            return {1'b1, 2'(e)};
      return 3'b000;
   endfunction

   task automatic cfg(input logic sel, input int idx, input int fld,
                      input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 2'(idx);
      cfg_field = 2'(fld); cfg_wdata = d;
      fetch_vld = 1'b0; dacc_vld = 1'b0;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      if (fld == 0) begin if (sel) m_da[idx] = d; else m_ia[idx] = d; end
      if (fld == 1) begin if (sel) m_dm[idx] = d; else m_im[idx] = d; end
      if (fld == 2) begin if (sel) m_dc[idx] = d[2:0]; else m_ic[idx] = d[2:0]; end
   endtask

   task automatic apply(input logic fv, input logic [31:0] fa,
                        input logic dv, input logic dr, input logic dw,
                        input logic [31:0] da, input string tag);
      logic [2:0] ei, ed;
      @(negedge clk);
      fetch_vld = fv; fetch_addr = fa;
      dacc_vld = dv; dacc_rd = dr; dacc_wr = dw; dacc_addr = da;
      ei = exp_ins(fv, fa);
      ed = exp_dat(dv, dr, dw, da);
      @(posedge clk);
      #1;
      vectors++;
      if ({ibrk_hit, ibrk_idx} !== ei || {dbrk_hit, dbrk_idx} !== ed) begin
         miscompares++;
         $display("FAIL %s: ihit/idx=%b/%0d dhit/idx=%b/%0d expected %b/%0d %b/%0d",
                  tag, ibrk_hit, ibrk_idx, dbrk_hit, dbrk_idx,
                  ei[2], ei[1:0], ed[2], ed[1:0]);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      miscompares++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] a;
      int k;
      int pick;
      void'($urandom(32'd5150));
      for (int e = 0; e < 4; e++) begin
         m_ia[e] = '0; m_im[e] = '0; m_ic[e] = '0;
         m_da[e] = '0; m_dm[e] = '0; m_dc[e] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      vectors++;
      if (ibrk_hit !== 1'b0 || dbrk_hit !== 1'b0 || ibrk_idx !== 2'd0 || dbrk_idx !== 2'd0) begin
         miscompares++;
         $display("FAIL R1: outputs %b%b%0d%0d expected 0000", ibrk_hit, dbrk_hit, ibrk_idx, dbrk_idx);
      end
      // R1 / R4: zero mask after reset would match, but entries are disabled
      apply(1, 32'h0, 1, 1, 1, 32'h0, "R1");

      // R2: aligned 256-byte range on entry 1
      cfg(0, 1, 0, 32'h0000_1000);
      cfg(0, 1, 1, 32'hFFFF_FF00);
      cfg(0, 1, 2, 32'h1);
      apply(1, 32'h0000_10A4, 0, 0, 0, 0, "R2");
      apply(1, 32'h0000_1100, 0, 0, 0, 0, "R2");
      // R7: fetch valid low
      apply(0, 32'h0000_1000, 0, 0, 0, 0, "R7");
      // R4: disable entry 1
      cfg(0, 1, 2, 32'h6);
      apply(1, 32'h0000_1000, 0, 0, 0, 0, "R4");
      cfg(0, 1, 2, 32'h1);
      // R5: nested range on entry 3
      cfg(0, 3, 0, 32'h0000_1000);
      cfg(0, 3, 1, 32'hFFFF_F000);
      cfg(0, 3, 2, 32'h1);
      apply(1, 32'h0000_1050, 0, 0, 0, 0, "R5");
      apply(1, 32'h0000_1F00, 0, 0, 0, 0, "R5");
      // R8 / R9: no match next cycle drops pulse and index
      apply(1, 32'h0000_9000, 0, 0, 0, 0, "R8");
      // R10: field 3 ignored, data group untouched by instruction writes
      cfg(0, 1, 3, 32'hFFFF_FFFF);
      apply(1, 32'h0000_1010, 1, 1, 1, 32'h0000_1010, "R10");
      // R5: zero mask on entry 0 matches all and wins
      cfg(0, 0, 2, 32'h1);
      apply(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R5");
      apply(1, 32'h0000_1010, 0, 0, 0, 0, "R5");
      cfg(0, 0, 2, 32'h0);

      // R3 / R6: data entry 2, read only
      cfg(1, 2, 0, 32'h0000_8000);
      cfg(1, 2, 1, 32'hFFFF_FFF0);
      cfg(1, 2, 2, 32'h3);
      apply(0, 0, 1, 1, 0, 32'h0000_8008, "R3");
      apply(0, 0, 1, 0, 1, 32'h0000_8008, "R6");
      apply(0, 0, 1, 1, 0, 32'h0000_8010, "R3");
      // R7: valid with no kind flag
      apply(0, 0, 1, 0, 0, 32'h0000_8008, "R7");
      apply(0, 0, 0, 1, 1, 32'h0000_8008, "R7");
      cfg(1, 2, 2, 32'h5);
      apply(0, 0, 1, 0, 1, 32'h0000_800F, "R6");
      apply(0, 0, 1, 1, 0, 32'h0000_800F, "R6");
      apply(0, 0, 1, 1, 1, 32'h0000_8004, "R6");
      // R5 with qualifiers: entry 1 read-only overlaps entry 2 write-only
      cfg(1, 1, 0, 32'h0000_8000);
      cfg(1, 1, 1, 32'hFFFF_FF00);
      cfg(1, 1, 2, 32'h3);
      apply(0, 0, 1, 0, 1, 32'h0000_8004, "R5");
      apply(0, 0, 1, 1, 1, 32'h0000_8004, "R5");
      // R6: instruction entries ignore kind bits
      cfg(0, 2, 0, 32'h0000_4000);
      cfg(0, 2, 1, 32'hFFFF_FFFF);
      cfg(0, 2, 2, 32'h7);
      apply(1, 32'h0000_4000, 0, 0, 0, 0, "R6");

      // Random mix for R2 R3 R5 R6
      for (int n = 0; n < 800; n++) begin
         if (n % 40 == 0) begin
            for (int e = 0; e < 4; e++) begin
               k = $urandom % 13;
               cfg(0, e, 0, $urandom & 32'h0000_FFF0);
               cfg(0, e, 1, 32'hFFFF_FFFF << k);
               cfg(0, e, 2, $urandom % 8);
               k = $urandom % 13;
               cfg(1, e, 0, $urandom & 32'h0000_FFF0);
               cfg(1, e, 1, (32'hFFFF_FFFF << k) ^ (($urandom % 4 == 0) ? 32'h10 : 32'h0));
               cfg(1, e, 2, $urandom % 8);
            end
         end
         pick = $urandom % 4;
         a = m_ia[pick] ^ ($urandom & 32'h0000_1FFF);
         if ($urandom % 8 == 0) a = $urandom;
         fetch_addr = a;
         pick = $urandom % 4;
         a = m_da[pick] ^ ($urandom & 32'h0000_1FFF);
         apply($urandom % 4 != 0, fetch_addr, $urandom % 4 != 0,
               1'($urandom), 1'($urandom), a, "R2 R3 R5 R6");
      end
      finish_run();
   end

endmodule